// File: doc/BRIEF.md
# Dual-Rail Operand Checker Using Product Comparison

This block watches two operand buses that travel in dual-rail form, each bit carried on a true wire and a false wire. It decides, once per presented pair, whether the rails are still self-consistent. It does not compare the wires bit by bit. Each rail word is turned into an odd signed number by appending a constant 1 below its least significant bit. The two true-rail numbers are multiplied together, and the two false-rail numbers are multiplied together.

When the encoding is correct in the evaluation phase, every false bit is the inverse of its true bit, so each false-rail number is the exact negative of its true-rail number. The two products are then equal. In the precharge phase each bit pair holds the same level on both wires, so both products are again equal. A fault that breaks either pattern makes the products differ. The difference of the products is tested for zero, and a nonzero difference raises the fault flag.

The result comes out two clock cycles after the inputs are sampled. It carries a valid strobe and a copy of the phase the check was made in. The flag is per check only; the block does not say which bit failed.

Top module: `dr_mult_fault_chk`

## Requirements
- R1: Each rail word r of width W is read as the signed (W+1)-bit two's-complement value {r, 1}, which equals 2r+1 taken modulo 2^(W+1).
- R2: In the evaluation phase (phase_eval = 1), inputs with a_false = ~a_true and b_false = ~b_true never raise fault.
- R3: In the precharge phase (phase_eval = 0), inputs with a_false = a_true and b_false = b_true never raise fault. Each bit pair may independently be 00 or 11.
- R4: Starting from a correct pattern of either phase, inverting any single bit of any of the four rails raises fault.
- R5: For any rail values, fault equals 1 exactly when (At*Bt) and (Af*Bf) differ at full width 2W+2, where At, Bt, Af and Bf are the R1 values. A flip of the same bit on both wires of a complementary pair therefore stays unflagged.
- R6: out_valid rises on the second rising clock edge after the edge that samples in_valid = 1, back to back with no gaps. fault is never 1 while out_valid is 0.
- R7: When out_valid is 1, out_phase_eval equals the phase_eval sampled with that check.
- R8: While rst is high at a rising edge, out_valid and fault are 0 after that edge, whatever the inputs.
- R9: The fault decision depends only on the four rail words. The same words give the same fault in either phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A check is presented this cycle |
| phase_eval | input | 1 | 1 = evaluation phase, 0 = precharge phase |
| a_true | input | W | True rail of operand A |
| a_false | input | W | False rail of operand A |
| b_true | input | W | True rail of operand B |
| b_false | input | W | False rail of operand B |
| out_valid | output | 1 | Result of a check is present |
| out_phase_eval | output | 1 | Phase of the check being reported |
| fault | output | 1 | Rails were inconsistent |

## Verification
The bench runs at width 4. It covers every complementary pair, every null pair, and every single-bit flip from each of those patterns in both phases. A design that appended 0 instead of 1, or that treated the operands as unsigned, would flag correct complementary traffic. A design that truncated the products or compared only part of them could let some flips through unflagged. A run of random rail words is scored against products computed in the bench. It includes symmetric double flips that must stay quiet, so a design that compared rails bit by bit would raise false alarms there. A back-to-back stream with a trailing idle gap exposes any miscount of the two-cycle latency or a valid strobe that outlives its data.

// File: rtl/drfc_pkg.sv
package drfc_pkg;

    typedef enum logic {
        PH_PRECHARGE = 1'b0,
        PH_EVALUATE  = 1'b1
    } phase_e;

    localparam int unsigned RAIL_COUNT = 2;
    localparam int unsigned RAIL_T     = 0;
    localparam int unsigned RAIL_F     = 1;

endpackage

// File: rtl/drfc_odd_ext.sv
module drfc_odd_ext #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0]      rail,
    output logic signed [W:0] odd_val
);
    // A rail word becomes the odd number 2*rail+1, read as signed.
    assign odd_val = $signed({rail, 1'b1});
endmodule

// File: rtl/drfc_smul.sv
module drfc_smul #(
    parameter int unsigned W = 8
) (
    input  logic signed [W:0]       x,
    input  logic signed [W:0]       y,
    output logic signed [2*W+1:0]   prod
);
    localparam int unsigned PW = 2 * W + 2;

    logic signed [PW-1:0] x_wide;
    logic signed [PW-1:0] y_wide;

    // Sign-extend both operands to the product width so that the product
    // keeps every bit.
    assign x_wide = {{(PW-W-1){x[W]}}, x};
    assign y_wide = {{(PW-W-1){y[W]}}, y};
    assign prod   = x_wide * y_wide;
endmodule

// File: rtl/drfc_zero_det.sv
module drfc_zero_det #(
    parameter int unsigned PW = 18
) (
    input  logic [PW-1:0] lhs,
    input  logic [PW-1:0] rhs,
    output logic          nonzero
);
    logic [PW-1:0] delta;

    assign delta   = lhs - rhs;
    assign nonzero = |delta;
endmodule

// File: rtl/dr_mult_fault_chk.sv
module dr_mult_fault_chk
    import drfc_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic         phase_eval,
    input  logic [W-1:0] a_true,
    input  logic [W-1:0] a_false,
    input  logic [W-1:0] b_true,
    input  logic [W-1:0] b_false,
    output logic         out_valid,
    output logic         out_phase_eval,
    output logic         fault
);
    localparam int unsigned PW = 2 * W + 2;

    typedef struct packed {
        logic                 vld;
        phase_e               ph;
        logic signed [PW-1:0] prod_t;
        logic signed [PW-1:0] prod_f;
    } prod_stage_t;

    typedef struct packed {
        logic   vld;
        phase_e ph;
        logic   flag;
    } flag_stage_t;

    logic [W-1:0]         a_rail [RAIL_COUNT];
    logic [W-1:0]         b_rail [RAIL_COUNT];
    logic signed [W:0]    a_odd  [RAIL_COUNT];
    logic signed [W:0]    b_odd  [RAIL_COUNT];
    logic signed [PW-1:0] prod   [RAIL_COUNT];

    assign a_rail[RAIL_T] = a_true;
    assign a_rail[RAIL_F] = a_false;
    assign b_rail[RAIL_T] = b_true;
    assign b_rail[RAIL_F] = b_false;

    for (genvar r = 0; r < RAIL_COUNT; r++) begin : g_rail
        drfc_odd_ext #(.W(W)) u_ext_a (.rail(a_rail[r]), .odd_val(a_odd[r]));
        drfc_odd_ext #(.W(W)) u_ext_b (.rail(b_rail[r]), .odd_val(b_odd[r]));
        drfc_smul    #(.W(W)) u_mul   (.x(a_odd[r]), .y(b_odd[r]), .prod(prod[r]));
    end

    prod_stage_t s1_q;
    flag_stage_t s2_q;
    logic        differ;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= '0;
        end else begin
            s1_q.vld    <= in_valid;
            s1_q.ph     <= phase_e'(phase_eval);
            s1_q.prod_t <= prod[RAIL_T];
            s1_q.prod_f <= prod[RAIL_F];
        end
    end

    drfc_zero_det #(.PW(PW)) u_zero (
        .lhs     (s1_q.prod_t),
        .rhs     (s1_q.prod_f),
        .nonzero (differ)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s2_q <= '0;
        end else begin
            s2_q.vld  <= s1_q.vld;
            s2_q.ph   <= s1_q.ph;
            s2_q.flag <= s1_q.vld & differ;
        end
    end

    assign out_valid      = s2_q.vld;
    assign out_phase_eval = (s2_q.ph == PH_EVALUATE);
    assign fault          = s2_q.flag;
endmodule

// File: rtl/drfc_checker.sv
module drfc_checker #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic         phase_eval,
    input logic [W-1:0] a_true,
    input logic [W-1:0] a_false,
    input logic [W-1:0] b_true,
    input logic [W-1:0] b_false,
    input logic         out_valid,
    input logic         out_phase_eval,
    input logic         fault
);
    logic [1:0] age;
    logic       rst_q;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst)            age <= 2'd0;
        else if (age != 2'd2) age <= age + 2'd1;
    end

    AST_LATENCY_VALID: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd2) |-> (out_valid == $past(in_valid, 2)));  // R6

    AST_FAULT_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
        fault |-> out_valid);  // R6

    AST_COMPL_QUIET: assert property (@(posedge clk) disable iff (rst)
        ((age == 2'd2) && $past(in_valid && (a_false == ~a_true) && (b_false == ~b_true), 2))
        |-> !fault);  // R2

    AST_NULL_QUIET: assert property (@(posedge clk) disable iff (rst)
        ((age == 2'd2) && $past(in_valid && (a_false == a_true) && (b_false == b_true), 2))
        |-> !fault);  // R3

    AST_ONE_SIDE_MISMATCH: assert property (@(posedge clk) disable iff (rst)
        ((age == 2'd2) && $past(in_valid && (a_false == a_true) && (b_false != b_true), 2))
        |-> fault);  // R5

    AST_PHASE_ECHO: assert property (@(posedge clk) disable iff (rst)
        ((age == 2'd2) && out_valid) |-> (out_phase_eval == $past(phase_eval, 2)));  // R7

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst_q |-> (!out_valid && !fault));  // R8
endmodule

bind dr_mult_fault_chk drfc_checker #(.W(W)) u_drfc_checker (
    .clk            (clk),
    .rst            (rst),
    .in_valid       (in_valid),
    .phase_eval     (phase_eval),
    .a_true         (a_true),
    .a_false        (a_false),
    .b_true         (b_true),
    .b_false        (b_false),
    .out_valid      (out_valid),
    .out_phase_eval (out_phase_eval),
    .fault          (fault)
);

// File: tb/test_dr_mult_fault_chk.sv
`timescale 1ns/1ps
module test_dr_mult_fault_chk;
    localparam int TW = 4;
    localparam int NSTREAM = 40;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic          phase_eval = 1'b0;
    logic [TW-1:0] a_true = '0, a_false = '0, b_true = '0, b_false = '0;
    logic          out_valid, out_phase_eval, fault;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  done  = 0;
    int unsigned lcg = 32'h1234_5678;

    always #2 clk = ~clk;

    dr_mult_fault_chk #(.W(TW)) i_dr_mult_fault_chk (
        .clk(clk), .rst(rst), .in_valid(in_valid), .phase_eval(phase_eval),
        .a_true(a_true), .a_false(a_false), .b_true(b_true), .b_false(b_false),
        .out_valid(out_valid), .out_phase_eval(out_phase_eval), .fault(fault)
    );

    // R1: signed value of {rail,1} on TW+1 bits.
    function automatic int odd_of(input logic [TW-1:0] r);
        int v;
        v = 2 * int'(r) + 1;
        if (v >= (1 << TW)) v = v - (1 << (TW + 1));
        return v;
    endfunction

    function automatic logic model(input logic [TW-1:0] at, af, bt, bf);
        return (odd_of(at) * odd_of(bt)) != (odd_of(af) * odd_of(bf));
    endfunction

    function automatic int unsigned next_rand();
        lcg = lcg * 32'd1103515245 + 32'd12345;
        return lcg >> 8;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Present one check, wait out the two-cycle latency, score it.
    task automatic run_vec(input logic [TW-1:0] at, af, bt, bf,
                           input logic ph, input logic exp, input string req);
        @(negedge clk);
        a_true = at; a_false = af; b_true = bt; b_false = bf;
        phase_eval = ph; in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        @(posedge clk);
        #1;
        chk({req, " valid"}, 32'(out_valid), 32'd1);
        chk({req, " fault"}, 32'(fault), 32'(exp));
        chk({req, " phase"}, 32'(out_phase_eval), 32'(ph));
    endtask

    logic [TW-1:0] s_at [NSTREAM], s_af [NSTREAM], s_bt [NSTREAM], s_bf [NSTREAM];
    logic          s_ph [NSTREAM];

    initial begin
        // R8: reset with an active faulting check on the inputs
        in_valid = 1'b1; a_true = 4'h0; a_false = 4'h0; b_true = 4'h0; b_false = 4'hF;
        repeat (3) @(posedge clk);
        #1;
        chk("R8 reset valid", 32'(out_valid), 32'd0);
        chk("R8 reset fault", 32'(fault), 32'd0);
        @(negedge clk);
        in_valid = 1'b0; rst = 1'b0;

        // R1: operand forming (appended 1, signed read)
        run_vec(4'h0, 4'h0, 4'h0, 4'hF, 1'b1, 1'b1, "R1 one-vs-minus-one");
        run_vec(4'h8, 4'h7, 4'h1, 4'hE, 1'b1, 1'b0, "R1 signed extremes");
        run_vec(4'h0, 4'h0, 4'h0, 4'h0, 1'b0, 1'b0, "R1 all-zero null");

        // R2: every complementary pair in evaluation
        for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++)
                run_vec(4'(a), ~4'(a), 4'(b), ~4'(b), 1'b1, 1'b0, "R2 complementary");

        // R3: every null pair in precharge
        for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++)
                run_vec(4'(a), 4'(a), 4'(b), 4'(b), 1'b0, 1'b0, "R3 null");

        // R4: single-bit flips on each rail, both phases
        for (int ph = 0; ph < 2; ph++)
            for (int a = 0; a < 16; a++)
                for (int b = 0; b < 16; b++)
                    for (int rail = 0; rail < 4; rail++)
                        for (int bit_i = 0; bit_i < TW; bit_i++) begin
                            logic [TW-1:0] at, af, bt, bf, m;
                            at = 4'(a); bt = 4'(b);
                            af = (ph == 1) ? ~at : at;
                            bf = (ph == 1) ? ~bt : bt;
                            m  = 4'(1 << bit_i);
                            case (rail)
                                0: at = at ^ m;
                                1: af = af ^ m;
                                2: bt = bt ^ m;
                                default: bf = bf ^ m;
                            endcase
                            run_vec(at, af, bt, bf, 1'(ph), 1'b1, "R4 single flip");
                        end

        // R5: symmetric double flip keeps products equal
        run_vec(4'h5 ^ 4'h2, ~4'h5 ^ 4'h2, 4'h3, 4'hC, 1'b1, 1'b0, "R5 double flip");

        // R5 and R9: random words scored arithmetically, each in both phases
        for (int k = 0; k < 1500; k++) begin
            logic [TW-1:0] at, af, bt, bf;
            logic e;
            int unsigned r;
            r = next_rand();
            at = r[3:0]; af = r[7:4]; bt = r[11:8]; bf = r[15:12];
            e = model(at, af, bt, bf);
            run_vec(at, af, bt, bf, 1'b1, e, "R5 random eval");
            run_vec(at, af, bt, bf, 1'b0, e, "R9 random precharge");
        end

        // R6 and R7: back-to-back stream then idle
        for (int k = 0; k < NSTREAM; k++) begin
            int unsigned r;
            r = next_rand();
            s_at[k] = r[3:0]; s_bt[k] = r[11:8];
            s_ph[k] = r[16];
            if (r[17]) begin
                s_af[k] = r[7:4]; s_bf[k] = r[15:12];
            end else begin
                s_af[k] = s_ph[k] ? ~s_at[k] : s_at[k];
                s_bf[k] = s_ph[k] ? ~s_bt[k] : s_bt[k];
            end
        end
        for (int i = 0; i < NSTREAM + 2; i++) begin
            @(negedge clk);
            if (i >= 2) begin
                chk("R6 stream valid", 32'(out_valid), 32'd1);
                chk("R6 stream fault", 32'(fault),
                    32'(model(s_at[i-2], s_af[i-2], s_bt[i-2], s_bf[i-2])));
                chk("R7 stream phase", 32'(out_phase_eval), 32'(s_ph[i-2]));
            end
            if (i < NSTREAM) begin
                a_true = s_at[i]; a_false = s_af[i]; b_true = s_bt[i]; b_false = s_bf[i];
                phase_eval = s_ph[i]; in_valid = 1'b1;
            end else begin
                in_valid = 1'b0;
                a_true = 4'h0; a_false = 4'h0; b_true = 4'h0; b_false = 4'hF;
            end
        end
        @(negedge clk);
        chk("R6 idle valid", 32'(out_valid), 32'd0);
        chk("R6 idle fault", 32'(fault), 32'd0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R6 watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule